// File: doc/BRIEF.md
# Carry-Save Shift Accumulator with Sign-Bit Subtraction

This block gathers a signed result from a sequence of signed partial words that arrive one per bit-cycle, least significant weight first. The usual source is a distributed-arithmetic lookup, where each word is the table output for one bit-slice of a set of operands. The accumulated value is held as two words in carry-save form, so a bit-cycle costs one full-adder delay whatever the width. The value is shifted right by one place on every bit-cycle, and the bit that drops off the bottom is resolved by a one-bit serial adder, so no precision is lost. The partial word of the final bit-cycle carries the sign-bit weight. That word is inverted bitwise and a carry-in of one is injected into the same carry-save row, which subtracts it with no second adder.

On the final bit-cycle the resolved low bits and the two high words are copied into a flush stage, and the accumulator is cleared for the next word in the same clock. One clock later a ripple-carry adder, enabled once per word, joins the high words. The block then presents the full-precision result with a one-clock valid strobe. Words may follow one another with no idle bit-cycle between them. Bit-cycles may also be spread out with idle clocks. A start flag discards whatever a broken-off word left behind.

Top module: `csacc_shift_acc`

## Requirements
- R1: While reset is asserted and after it is released, `res_vld_o` is 0 and `res_o` is 0 until the first word completes.
- R2: For a word of NB bit-cycles with signed two's-complement partials P0..P(NB-1) in arrival order, `res_o` equals the sum of Pk·2^k for k < NB-1, minus P(NB-1)·2^(NB-1), as a signed PW+NB-bit value.
- R3: The partial of the bit-cycle flagged by `last_i` is subtracted. A word whose only nonzero partial is the last one, including the most negative partial, yields -P·2^(NB-1).
- R4: If `last_i` is taken (with `bit_en_i` high) at clock edge k, `res_vld_o` is 1 for exactly the clock period after edge k+1.
- R5: `res_o` changes only in a clock period where `res_vld_o` is 1 and otherwise holds its value.
- R6: Words sent back to back, with the first bit-cycle of a word in the clock after the `last_i` bit-cycle of the previous one, each give their own R2 result with no carry-over.
- R7: Clocks with `bit_en_i` at 0 are ignored: the `start_i`, `last_i` and `part_i` values presented on them change no result.
- R8: A bit-cycle with `start_i` at 1 begins a new word from zero, and discards the partial sum of any unfinished word.
- R9: Extreme partials (all at the most positive or all at the most negative value) give exact results with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit-cycle per clock when `bit_en_i` is high |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Marks a clock as a bit-cycle |
| start_i | input | 1 | First bit-cycle of a word; drops prior partial state |
| last_i | input | 1 | Final bit-cycle of a word; subtracts the partial and flushes |
| part_i | input | PW | Signed partial word for this bit-cycle |
| res_o | output | PW+NB | Signed full-precision result |
| res_vld_o | output | 1 | One-clock strobe marking a new result |

## Verification
The bench focuses on the sign-bit cycle, the clear and the bit-cycle enable. If the sign control were lost, words whose last partial is nonzero would come out with the wrong sign, and the most negative partial exposes any error in the carry-in. A clear that collided with the next word's first accumulate would leak the previous result into back-to-back words. A missing serial carry or an arithmetic shift done in the wrong width would show up as off-by-one or wrapped values at the extreme partials. Idle clocks that carry garbage on `part_i`, `last_i` and `start_i`, together with a word broken off and restarted with `start_i`, catch an accumulator that ignores the enable or keeps stale state.

// File: rtl/csacc_pkg.sv
package csacc_pkg;
  // identical top bits kept on the carry-save words so that each word can be
  // shifted on its own without losing the sign of the pair
  localparam int unsigned GUARD = 3;

  function automatic int unsigned high_width(input int unsigned pw);
    return pw + GUARD;
  endfunction
endpackage

// File: rtl/csacc_csa_row.sv
module csacc_csa_row #(
  parameter int unsigned N = 15
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] car_o
);
  logic [N-1:0] maj;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    assign maj[i]   = (a_i[i] & b_i[i]) | (c_i[i] & (a_i[i] ^ b_i[i]));
  end

  // carry word weighted one place up; the free LSB takes the injected carry
  assign car_o = {maj[N-2:0], cin_i};
endmodule

// File: rtl/csacc_resolve.sv
module csacc_resolve #(
  parameter int unsigned HW = 15,
  parameter int unsigned PW = 12,
  parameter int unsigned NB = 8,
  localparam int unsigned RW = PW + NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [HW-1:0] s_i,
  input  logic [HW-1:0] c_i,
  input  logic          cin_i,
  input  logic [NB-1:0] low_i,
  output logic [RW-1:0] res_o,
  output logic          vld_o
);
  logic [HW-1:0] hi_sum;
  logic [RW-1:0] res_d, res_q;
  logic          vld_q;

  always_comb begin
    hi_sum = s_i + c_i + {{(HW-1){1'b0}}, cin_i};
    res_d  = en_i ? {hi_sum[PW-1:0], low_i} : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= en_i;
    end
  end

  assign res_o = res_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/csacc_shift_acc.sv
module csacc_shift_acc #(
  parameter int unsigned PW = 12,
  parameter int unsigned NB = 8,
  localparam int unsigned HW = csacc_pkg::high_width(PW),
  localparam int unsigned RW = PW + NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en_i,
  input  logic          start_i,
  input  logic          last_i,
  input  logic [PW-1:0] part_i,
  output logic [RW-1:0] res_o,
  output logic          res_vld_o
);
  // bit-cycle accumulator state
  logic [HW-1:0] sum_q, car_q, sum_d, car_d;
  logic          sy_q, sy_d;
  logic [NB-1:0] low_q, low_d;
  // flush stage, loaded once per word
  logic [HW-1:0] fs_q, fc_q, fs_d, fc_d;
  logic          fy_q, fy_d;
  logic [NB-1:0] fl_q, fl_d;
  logic          fp_q, fp_d;

  logic [HW-1:0] base_s, base_c, addend, t_s, t_c, sh_s, sh_c;
  logic          base_y, out_bit, y_nxt;
  logic [NB-1:0] low_nxt;

  assign base_s = start_i ? '0 : sum_q;
  assign base_c = start_i ? '0 : car_q;
  assign base_y = start_i ? 1'b0 : sy_q;
  // sign control: the last bit-cycle inverts the partial
  assign addend = {{(HW-PW){part_i[PW-1]}}, part_i} ^ {HW{last_i}};

  csacc_csa_row #(.N(HW)) u_csa (
    .a_i   (base_s),
    .b_i   (base_c),
    .c_i   (addend),
    .cin_i (last_i),
    .sum_o (t_s),
    .car_o (t_c)
  );

  // serial adder resolving the bit that leaves on the right shift
  assign out_bit = t_s[0] ^ t_c[0] ^ base_y;
  assign y_nxt   = (t_s[0] & t_c[0]) | (base_y & (t_s[0] ^ t_c[0]));
  assign sh_s    = {t_s[HW-1], t_s[HW-1:1]};
  assign sh_c    = {t_c[HW-1], t_c[HW-1:1]};
  assign low_nxt = {out_bit, low_q[NB-1:1]};

  always_comb begin
    sum_d = sum_q;
    car_d = car_q;
    sy_d  = sy_q;
    low_d = low_q;
    fs_d  = fs_q;
    fc_d  = fc_q;
    fy_d  = fy_q;
    fl_d  = fl_q;
    fp_d  = 1'b0;
    if (bit_en_i) begin
      low_d = low_nxt;
      if (last_i) begin
        fs_d  = sh_s;
        fc_d  = sh_c;
        fy_d  = y_nxt;
        fl_d  = low_nxt;
        fp_d  = 1'b1;
        sum_d = '0;
        car_d = '0;
        sy_d  = 1'b0;
      end else begin
        sum_d = sh_s;
        car_d = sh_c;
        sy_d  = y_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      car_q <= '0;
      sy_q  <= 1'b0;
      low_q <= '0;
      fs_q  <= '0;
      fc_q  <= '0;
      fy_q  <= 1'b0;
      fl_q  <= '0;
      fp_q  <= 1'b0;
    end else begin
      sum_q <= sum_d;
      car_q <= car_d;
      sy_q  <= sy_d;
      low_q <= low_d;
      fs_q  <= fs_d;
      fc_q  <= fc_d;
      fy_q  <= fy_d;
      fl_q  <= fl_d;
      fp_q  <= fp_d;
    end
  end

  csacc_resolve #(.HW(HW), .PW(PW), .NB(NB)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (fp_q),
    .s_i   (fs_q),
    .c_i   (fc_q),
    .cin_i (fy_q),
    .low_i (fl_q),
    .res_o (res_o),
    .vld_o (res_vld_o)
  );

  // R4: strobe two edges after the last bit-cycle
  p_strobe_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && last_i) |=> ##1 res_vld_o);
  // R4: no strobe without a last bit-cycle two edges earlier
  p_strobe_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $past(bit_en_i && last_i, 2));
  // R5: result holds between strobes
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> $stable(res_o));
  // R7: idle clocks leave the accumulator untouched
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> ($stable(sum_q) && $stable(car_q) && $stable(sy_q) && $stable(low_q)));
  // R6: the flush leaves an empty accumulator for the next word
  p_clear_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && last_i) |=> (sum_q == '0 && car_q == '0 && !sy_q));
  // R9: carry-save row outputs keep their guard bits, so separate shifts are exact
  p_guard_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_s[HW-1] == t_s[HW-2]);
  p_guard_car_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_c[HW-1] == t_c[HW-2]);
endmodule

// File: tb/tb_csacc_shift_acc.sv
module tb_csacc_shift_acc;
  localparam int PW = 12;
  localparam int NB = 8;
  localparam int RW = PW + NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en_i = 1'b0;
  logic          start_i = 1'b0;
  logic          last_i = 1'b0;
  logic [PW-1:0] part_i = '0;
  logic [RW-1:0] res_o;
  logic          res_vld_o;

  csacc_shift_acc #(.PW(PW), .NB(NB)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en_i(bit_en_i), .start_i(start_i),
    .last_i(last_i), .part_i(part_i), .res_o(res_o), .res_vld_o(res_vld_o)
  );

  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    cmp_on = 1'b0;
  string cur_req = "R1";

  // behavioural reference: integer sum per word, two-stage result pipeline
  longint acc_m = 0;
  int     idx_m = 0;
  longint fl_m = 0;
  bit     pend_m = 1'b0;
  longint res_m = 0;
  bit     vld_m = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      acc_m = 0; idx_m = 0; fl_m = 0; pend_m = 0; res_m = 0; vld_m = 0;
    end else begin
      vld_m = pend_m;
      if (pend_m) res_m = fl_m;
      pend_m = 0;
      if (bit_en_i) begin
        longint p;
        p = longint'($signed(part_i));
        if (start_i) begin acc_m = 0; idx_m = 0; end
        if (last_i) acc_m = acc_m - p * (longint'(1) << idx_m);
        else        acc_m = acc_m + p * (longint'(1) << idx_m);
        idx_m++;
        if (last_i) begin fl_m = acc_m; pend_m = 1; acc_m = 0; idx_m = 0; end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_chk++;
      if (res_vld_o !== vld_m || longint'($signed(res_o)) != res_m) begin
        n_bad++;
        $display("FAIL %s: vld=%0b res=%0d expected vld=%0b res=%0d",
                 cur_req, res_vld_o, $signed(res_o), vld_m, res_m);
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      finish_up();
    end
  end

  task automatic bitc(input int p, input bit st, input bit ls);
    @(negedge clk);
    bit_en_i = 1'b1; start_i = st; last_i = ls; part_i = p[PW-1:0];
  endtask

  // idle clock carrying junk on every control and data input (R7)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en_i = 1'b0; start_i = i[0]; last_i = ~i[0]; part_i = PW'(12'h5A3 + i);
    end
  endtask

  task automatic send_word(input int pv[NB], input bit st, input int gap);
    for (int k = 0; k < NB; k++) begin
      bitc(pv[k], (k == 0) && st, k == NB - 1);
      if (gap > 0 && k < NB - 1) idle(gap);
    end
  endtask

  initial begin
    int pv[NB];
    // R1: reset state
    repeat (3) @(negedge clk);
    cur_req = "R1";
    n_chk++;
    if (res_vld_o !== 1'b0 || res_o !== '0) begin
      n_bad++;
      $display("FAIL R1: vld=%0b res=%0d expected vld=0 res=0", res_vld_o, res_o);
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(3);

    // R2: several patterns
    cur_req = "R2";
    for (int w = 0; w < 6; w++) begin
      for (int k = 0; k < NB; k++) pv[k] = ((w * 613 + k * 1171 + 97) % 4096) - 2048;
      send_word(pv, 1'b0, 0);
      idle(3);
    end

    // R3: only the sign-bit cycle nonzero, including the most negative partial
    cur_req = "R3";
    for (int k = 0; k < NB; k++) pv[k] = 0;
    pv[NB-1] = -2048; send_word(pv, 1'b0, 0); idle(3);
    pv[NB-1] = 2047;  send_word(pv, 1'b0, 0); idle(3);
    pv[NB-1] = -1;    send_word(pv, 1'b0, 0); idle(3);

    // R9: extreme partials
    cur_req = "R9";
    for (int k = 0; k < NB; k++) pv[k] = 2047;
    send_word(pv, 1'b0, 0); idle(3);
    for (int k = 0; k < NB; k++) pv[k] = -2048;
    send_word(pv, 1'b0, 0); idle(3);
    for (int k = 0; k < NB; k++) pv[k] = (k == NB - 1) ? -2048 : 2047;
    send_word(pv, 1'b0, 0); idle(3);

    // R6: back-to-back words, no idle bit-cycle
    cur_req = "R6";
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < NB; k++) pv[k] = ((w * 389 + k * 733 + 5) % 4096) - 2048;
      send_word(pv, 1'b0, 0);
    end
    idle(4);

    // R7: idle clocks spread through a word
    cur_req = "R7";
    for (int k = 0; k < NB; k++) pv[k] = 300 * k - 1000;
    send_word(pv, 1'b0, 2);
    idle(4);

    // R8: broken-off word then restart with start flag
    cur_req = "R8";
    bitc(1500, 1'b1, 1'b0); bitc(-700, 1'b0, 1'b0); bitc(1234, 1'b0, 1'b0);
    for (int k = 0; k < NB; k++) pv[k] = 50 * k + 7;
    send_word(pv, 1'b1, 0);
    idle(4);

    // R4 / R5: long quiet stretch, output must hold and strobe stay low
    cur_req = "R5";
    idle(12);
    cur_req = "R4";
    for (int k = 0; k < NB; k++) pv[k] = (k % 2 == 0) ? 1 : -1;
    send_word(pv, 1'b1, 0);
    idle(5);

    finish_up();
  end
endmodule